// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to the execute stage of a small 32-bit soft processor and decides, once per cycle, whether an external interrupt, a hardware break, a software break, a hardware exception or a translation fault is taken. When one is taken, the block produces every architectural update needed to enter its handler. These updates are the link-register write (index and value), the new machine-status word, the exception status and address values, the saved branch target and the redirected program counter. The pipeline applies them as they come.

The pipeline presents the current program counter, status word, exception status, branch target and the two instruction flags: delay slot, and immediate prefix pending. It also presents a flag telling whether the branch owning the delay slot carried its own immediate prefix. Request lines and translation-fault details complete the inputs. The entry is resolved in the cycle the requests are presented. All results appear on registered outputs on the next clock edge, with `take_o` marking the cycle in which they are valid. The handler base address and the availability of hardware exceptions are parameters.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `take_o` is high, `pc_o` is BASE_VEC+0x10 for an interrupt, BASE_VEC+0x18 for a hardware break, and BASE_VEC+0x20 for a hardware exception or a translation fault.
- R2: An interrupt is taken only when `irq_req_i` is high, status bit 1 (interrupt enable) is set, status bits 3 (break in progress) and 9 (exception in progress) are both clear, and neither `in_dslot_i` nor `imm_pend_i` is set.
- R3: On every entry, status bit 13 (translation on) is copied to bit 14, and bit 11 (user mode) is copied to bit 12. Bits 13 and 11 are then cleared. Every other status bit passes through unchanged unless another requirement names it.
- R4: An interrupt writes the current PC to link register 14 and clears status bit 1.
- R5: A hardware break writes the current PC to link register 16, sets status bit 3 and jumps to its vector. A software break sets status bit 3, makes no link write and jumps to `btarget_i`.
- R6: A hardware exception writes PC+4 to link register 17, sets status bit 9, and writes ESR as `esr_i` with bit 12 replaced by the delay-slot flag.
- R7: A hardware exception or translation fault raised in a delay slot writes `btarget_i` to BTR and sets ESR bit 12. Outside a delay slot, BTR is not written and bit 12 is clear.
- R8: A translation fault writes link register 17 with a rewound PC. The rewind is PC-4 in a delay slot, PC-8 in a delay slot whose branch had an immediate prefix, PC-4 when only an immediate prefix is pending, and PC otherwise. It also sets status bit 9.
- R9: A translation fault writes the faulting address to EAR. It writes ESR as 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss, plus bit 10 for a store and bit 12 per R7, with all other bits zero.
- R10: With HAS_HW_EXC = 0, `hw_exc_req_i` has no effect. Any other request is still arbitrated as if it were absent.
- R11: `flag_clr_o` is high in every cycle in which `take_o` is high, telling the pipeline to drop its delay-slot and prefix flags.
- R12: Coinciding requests are served in the order translation fault, hardware exception, hardware break, software break, interrupt. `kind_o` reports 5, 4, 2, 3 and 1 respectively.
- R13: Results appear exactly one clock after the requests are presented. In every cycle without an entry, and after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | XLEN | Current program counter |
| msr_i | input | XLEN | Current machine-status word |
| esr_i | input | XLEN | Current exception status |
| in_dslot_i | input | 1 | Instruction is in a delay slot |
| imm_pend_i | input | 1 | Immediate prefix pending |
| br_had_imm_i | input | 1 | Branch owning the delay slot had a prefix |
| btarget_i | input | XLEN | Pending branch target |
| irq_req_i | input | 1 | External interrupt request |
| hw_exc_req_i | input | 1 | Hardware exception request |
| hw_brk_req_i | input | 1 | Hardware break request |
| sw_brk_req_i | input | 1 | Software break instruction |
| mmu_fault_i | input | 1 | Translation fault |
| mmu_miss_i | input | 1 | Fault is a miss (else protection) |
| mmu_ifetch_i | input | 1 | Fault on an instruction fetch |
| mmu_store_i | input | 1 | Fault on a store |
| mmu_addr_i | input | XLEN | Faulting address |
| take_o | output | 1 | An entry is taken this cycle |
| kind_o | output | 3 | Entry kind code |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | XLEN | Link register value |
| msr_o | output | XLEN | New status word |
| esr_we_o | output | 1 | ESR write strobe |
| esr_o | output | XLEN | New ESR |
| ear_we_o | output | 1 | EAR write strobe |
| ear_o | output | XLEN | New EAR |
| btr_we_o | output | 1 | BTR write strobe |
| btr_o | output | XLEN | New BTR |
| pc_o | output | XLEN | Handler program counter |
| flag_clr_o | output | 1 | Clear delay-slot and prefix flags |

## Verification
The cases of most interest are cycles where a fault or exception lands on an instruction that also has an interrupt pending. They also include cycles where a hardware break meets a software break or an interrupt. The bench raises such request sets together, in one cycle, with the interrupt otherwise eligible. It judges the result against a behavioural model by kind code, vector, link write and status word. A second instance built without hardware exceptions gets the same stimulus, which shows that a suppressed exception hands the cycle to the next request in line.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_IRQ   = 3'd1,
    K_HWBRK = 3'd2,
    K_SWBRK = 3'd3,
    K_HWEXC = 3'd4,
    K_MMU   = 3'd5
  } entry_kind_e;

  // status word bit positions; each saved copy sits one place above its live bit
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = 12;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = 14;

  localparam int ES_STORE = 10;
  localparam int ES_DSLOT = 12;

  localparam int OFF_IRQ   = 'h10;
  localparam int OFF_HWBRK = 'h18;
  localparam int OFF_EXC   = 'h20;

  localparam int INSN_BYTES = 4;
  localparam int IDX_W      = 5;

  localparam logic [IDX_W-1:0] LNK_IRQ = 5'd14;
  localparam logic [IDX_W-1:0] LNK_BRK = 5'd16;
  localparam logic [IDX_W-1:0] LNK_EXC = 5'd17;

  localparam logic [4:0] FCODE_BASE = 5'd16;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter bit HAS_HW_EXC = 1'b1
) (
  input  logic        irq_req_i,
  input  logic        hw_exc_req_i,
  input  logic        hw_brk_req_i,
  input  logic        sw_brk_req_i,
  input  logic        mmu_fault_i,
  input  logic        st_ie_i,
  input  logic        st_bip_i,
  input  logic        st_eip_i,
  input  logic        in_dslot_i,
  input  logic        imm_pend_i,
  output entry_kind_e kind_o
);
  logic irq_ok;
  logic exc_ok;

  always_comb begin
    irq_ok = irq_req_i & st_ie_i & ~st_bip_i & ~st_eip_i & ~in_dslot_i & ~imm_pend_i;
    exc_ok = HAS_HW_EXC & hw_exc_req_i;
    if (mmu_fault_i)       kind_o = K_MMU;
    else if (exc_ok)       kind_o = K_HWEXC;
    else if (hw_brk_req_i) kind_o = K_HWBRK;
    else if (sw_brk_req_i) kind_o = K_SWBRK;
    else if (irq_ok)       kind_o = K_IRQ;
    else                   kind_o = K_NONE;
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  BASE_VEC = '0
) (
  input  entry_kind_e      kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  msr_i,
  input  logic [XLEN-1:0]  esr_i,
  input  logic             in_dslot_i,
  input  logic             imm_pend_i,
  input  logic             br_had_imm_i,
  input  logic [XLEN-1:0]  btarget_i,
  input  logic             mmu_miss_i,
  input  logic             mmu_ifetch_i,
  input  logic             mmu_store_i,
  input  logic [XLEN-1:0]  mmu_addr_i,
  output logic             take_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic [XLEN-1:0]  msr_o,
  output logic             esr_we_o,
  output logic [XLEN-1:0]  esr_o,
  output logic             ear_we_o,
  output logic [XLEN-1:0]  ear_o,
  output logic             btr_we_o,
  output logic [XLEN-1:0]  btr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             flag_clr_o
);
  localparam logic [XLEN-1:0] LIVE_MASK  = (XLEN'(1) << ST_VM) | (XLEN'(1) << ST_UM);
  localparam logic [XLEN-1:0] SAVED_MASK = LIVE_MASK << 1;
  localparam logic [XLEN-1:0] STEP       = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] stacked;
  logic [XLEN-1:0] rewind;
  logic [4:0]      fcode;

  always_comb begin
    stacked = (msr_i & ~(LIVE_MASK | SAVED_MASK)) | ((msr_i & LIVE_MASK) << 1);
    if (in_dslot_i)      rewind = br_had_imm_i ? (STEP << 1) : STEP;
    else if (imm_pend_i) rewind = STEP;
    else                 rewind = '0;
    fcode = FCODE_BASE + {3'b000, mmu_miss_i, mmu_ifetch_i};
  end

  always_comb begin
    take_o      = 1'b0;
    link_we_o   = 1'b0;
    link_idx_o  = '0;
    link_data_o = '0;
    msr_o       = '0;
    esr_we_o    = 1'b0;
    esr_o       = '0;
    ear_we_o    = 1'b0;
    ear_o       = '0;
    btr_we_o    = 1'b0;
    btr_o       = '0;
    pc_o        = '0;
    flag_clr_o  = 1'b0;
    if (kind_i != K_NONE) begin
      take_o     = 1'b1;
      flag_clr_o = 1'b1;
      msr_o      = stacked;
      unique case (kind_i)
        K_IRQ: begin
          msr_o[ST_IE] = 1'b0;
          link_we_o    = 1'b1;
          link_idx_o   = LNK_IRQ;
          link_data_o  = pc_i;
          pc_o         = BASE_VEC + XLEN'(OFF_IRQ);
        end
        K_HWBRK: begin
          msr_o[ST_BIP] = 1'b1;
          link_we_o     = 1'b1;
          link_idx_o    = LNK_BRK;
          link_data_o   = pc_i;
          pc_o          = BASE_VEC + XLEN'(OFF_HWBRK);
        end
        K_SWBRK: begin
          msr_o[ST_BIP] = 1'b1;
          pc_o          = btarget_i;
        end
        K_HWEXC: begin
          msr_o[ST_EIP]   = 1'b1;
          link_we_o       = 1'b1;
          link_idx_o      = LNK_EXC;
          link_data_o     = pc_i + STEP;
          esr_we_o        = 1'b1;
          esr_o           = esr_i;
          esr_o[ES_DSLOT] = in_dslot_i;
          btr_we_o        = in_dslot_i;
          btr_o           = in_dslot_i ? btarget_i : '0;
          pc_o            = BASE_VEC + XLEN'(OFF_EXC);
        end
        default: begin
          msr_o[ST_EIP]   = 1'b1;
          link_we_o       = 1'b1;
          link_idx_o      = LNK_EXC;
          link_data_o     = pc_i - rewind;
          esr_we_o        = 1'b1;
          esr_o           = XLEN'(fcode);
          esr_o[ES_STORE] = mmu_store_i;
          esr_o[ES_DSLOT] = in_dslot_i;
          ear_we_o        = 1'b1;
          ear_o           = mmu_addr_i;
          btr_we_o        = in_dslot_i;
          btr_o           = in_dslot_i ? btarget_i : '0;
          pc_o            = BASE_VEC + XLEN'(OFF_EXC);
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] BASE_VEC   = '0,
  parameter bit              HAS_HW_EXC = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] esr_i,
  input  logic            in_dslot_i,
  input  logic            imm_pend_i,
  input  logic            br_had_imm_i,
  input  logic [XLEN-1:0] btarget_i,
  input  logic            irq_req_i,
  input  logic            hw_exc_req_i,
  input  logic            hw_brk_req_i,
  input  logic            sw_brk_req_i,
  input  logic            mmu_fault_i,
  input  logic            mmu_miss_i,
  input  logic            mmu_ifetch_i,
  input  logic            mmu_store_i,
  input  logic [XLEN-1:0] mmu_addr_i,
  output logic            take_o,
  output logic [2:0]      kind_o,
  output logic            link_we_o,
  output logic [4:0]      link_idx_o,
  output logic [XLEN-1:0] link_data_o,
  output logic [XLEN-1:0] msr_o,
  output logic            esr_we_o,
  output logic [XLEN-1:0] esr_o,
  output logic            ear_we_o,
  output logic [XLEN-1:0] ear_o,
  output logic            btr_we_o,
  output logic [XLEN-1:0] btr_o,
  output logic [XLEN-1:0] pc_o,
  output logic            flag_clr_o
);
  entry_kind_e     kind_d;
  logic            take_d, link_we_d, esr_we_d, ear_we_d, btr_we_d, flag_clr_d;
  logic [4:0]      link_idx_d;
  logic [XLEN-1:0] link_data_d, msr_d, esr_d, ear_d, btr_d, pc_d;

  exc_entry_arb #(.HAS_HW_EXC(HAS_HW_EXC)) u_arb (
    .irq_req_i   (irq_req_i),
    .hw_exc_req_i(hw_exc_req_i),
    .hw_brk_req_i(hw_brk_req_i),
    .sw_brk_req_i(sw_brk_req_i),
    .mmu_fault_i (mmu_fault_i),
    .st_ie_i     (msr_i[ST_IE]),
    .st_bip_i    (msr_i[ST_BIP]),
    .st_eip_i    (msr_i[ST_EIP]),
    .in_dslot_i  (in_dslot_i),
    .imm_pend_i  (imm_pend_i),
    .kind_o      (kind_d)
  );

  exc_entry_calc #(.XLEN(XLEN), .BASE_VEC(BASE_VEC)) u_calc (
    .kind_i      (kind_d),
    .pc_i        (pc_i),
    .msr_i       (msr_i),
    .esr_i       (esr_i),
    .in_dslot_i  (in_dslot_i),
    .imm_pend_i  (imm_pend_i),
    .br_had_imm_i(br_had_imm_i),
    .btarget_i   (btarget_i),
    .mmu_miss_i  (mmu_miss_i),
    .mmu_ifetch_i(mmu_ifetch_i),
    .mmu_store_i (mmu_store_i),
    .mmu_addr_i  (mmu_addr_i),
    .take_o      (take_d),
    .link_we_o   (link_we_d),
    .link_idx_o  (link_idx_d),
    .link_data_o (link_data_d),
    .msr_o       (msr_d),
    .esr_we_o    (esr_we_d),
    .esr_o       (esr_d),
    .ear_we_o    (ear_we_d),
    .ear_o       (ear_d),
    .btr_we_o    (btr_we_d),
    .btr_o       (btr_d),
    .pc_o        (pc_d),
    .flag_clr_o  (flag_clr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o      <= 1'b0;
      kind_o      <= '0;
      link_we_o   <= 1'b0;
      link_idx_o  <= '0;
      link_data_o <= '0;
      msr_o       <= '0;
      esr_we_o    <= 1'b0;
      esr_o       <= '0;
      ear_we_o    <= 1'b0;
      ear_o       <= '0;
      btr_we_o    <= 1'b0;
      btr_o       <= '0;
      pc_o        <= '0;
      flag_clr_o  <= 1'b0;
    end else begin
      take_o      <= take_d;
      kind_o      <= kind_d;
      link_we_o   <= link_we_d;
      link_idx_o  <= link_idx_d;
      link_data_o <= link_data_d;
      msr_o       <= msr_d;
      esr_we_o    <= esr_we_d;
      esr_o       <= esr_d;
      ear_we_o    <= ear_we_d;
      ear_o       <= ear_d;
      btr_we_o    <= btr_we_d;
      btr_o       <= btr_d;
      pc_o        <= pc_d;
      flag_clr_o  <= flag_clr_d;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] BASE_VEC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] msr_i,
  input logic            irq_req_i,
  input logic            hw_exc_req_i,
  input logic            hw_brk_req_i,
  input logic            sw_brk_req_i,
  input logic            mmu_fault_i,
  input logic            take_o,
  input logic [2:0]      kind_o,
  input logic [XLEN-1:0] msr_o,
  input logic [XLEN-1:0] pc_o,
  input logic            flag_clr_o
);
  a_r1_irq_vector: assert property (@(posedge clk) disable iff (rst)
    (take_o && kind_o == 3'd1) |-> pc_o == BASE_VEC + XLEN'(OFF_IRQ));

  a_r2_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && !msr_i[ST_IE] && !hw_exc_req_i && !hw_brk_req_i
     && !sw_brk_req_i && !mmu_fault_i) |=> !take_o);

  a_r3_modes_off: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!msr_o[ST_VM] && !msr_o[ST_UM]));

  a_r3_vm_stacked: assert property (@(posedge clk) disable iff (rst)
    mmu_fault_i |=> msr_o[ST_VMS] == $past(msr_i[ST_VM]));

  a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
    take_o |-> flag_clr_o);

  a_r12_mmu_wins: assert property (@(posedge clk) disable iff (rst)
    mmu_fault_i |=> (take_o && kind_o == 3'd5));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(irq_req_i || hw_exc_req_i || hw_brk_req_i || sw_brk_req_i || mmu_fault_i)
    |=> (!take_o && pc_o == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .BASE_VEC(BASE_VEC)) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  localparam logic [31:0] BASE = 32'h0000_8000;

  typedef struct packed {
    logic        take;
    logic [2:0]  kind;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] ldat;
    logic [31:0] msr;
    logic        ewe;
    logic [31:0] esr;
    logic        awe;
    logic [31:0] ear;
    logic        bwe;
    logic [31:0] btr;
    logic [31:0] pc;
    logic        fclr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc = '0, msr = '0, esr = '0, btgt = '0, maddr = '0;
  logic dslot = 0, imm = 0, brimm = 0;
  logic irq = 0, hwexc = 0, hwbrk = 0, swbrk = 0, mmu = 0, miss = 0, ifet = 0, store = 0;

  exp_t a, b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl #(.BASE_VEC(BASE), .HAS_HW_EXC(1'b1)) u_exc_entry_ctrl (
    .clk(clk), .rst(rst), .pc_i(pc), .msr_i(msr), .esr_i(esr),
    .in_dslot_i(dslot), .imm_pend_i(imm), .br_had_imm_i(brimm), .btarget_i(btgt),
    .irq_req_i(irq), .hw_exc_req_i(hwexc), .hw_brk_req_i(hwbrk), .sw_brk_req_i(swbrk),
    .mmu_fault_i(mmu), .mmu_miss_i(miss), .mmu_ifetch_i(ifet), .mmu_store_i(store),
    .mmu_addr_i(maddr),
    .take_o(a.take), .kind_o(a.kind), .link_we_o(a.lwe), .link_idx_o(a.lidx),
    .link_data_o(a.ldat), .msr_o(a.msr), .esr_we_o(a.ewe), .esr_o(a.esr),
    .ear_we_o(a.awe), .ear_o(a.ear), .btr_we_o(a.bwe), .btr_o(a.btr),
    .pc_o(a.pc), .flag_clr_o(a.fclr)
  );

  exc_entry_ctrl #(.BASE_VEC(BASE), .HAS_HW_EXC(1'b0)) u_exc_entry_ctrl_noexc (
    .clk(clk), .rst(rst), .pc_i(pc), .msr_i(msr), .esr_i(esr),
    .in_dslot_i(dslot), .imm_pend_i(imm), .br_had_imm_i(brimm), .btarget_i(btgt),
    .irq_req_i(irq), .hw_exc_req_i(hwexc), .hw_brk_req_i(hwbrk), .sw_brk_req_i(swbrk),
    .mmu_fault_i(mmu), .mmu_miss_i(miss), .mmu_ifetch_i(ifet), .mmu_store_i(store),
    .mmu_addr_i(maddr),
    .take_o(b.take), .kind_o(b.kind), .link_we_o(b.lwe), .link_idx_o(b.lidx),
    .link_data_o(b.ldat), .msr_o(b.msr), .esr_we_o(b.ewe), .esr_o(b.esr),
    .ear_we_o(b.awe), .ear_o(b.ear), .btr_we_o(b.bwe), .btr_o(b.btr),
    .pc_o(b.pc), .flag_clr_o(b.fclr)
  );

  // behavioural reference: what the handler entry must look like
  function automatic exp_t model(bit has_exc);
    exp_t e = '0;
    int k = 0;
    bit irq_ok = irq && msr[1] && !msr[3] && !msr[9] && !dslot && !imm;
    if (mmu) k = 5;
    else if (hwexc && has_exc) k = 4;
    else if (hwbrk) k = 2;
    else if (swbrk) k = 3;
    else if (irq_ok) k = 1;
    if (k == 0) return e;
    e.take = 1; e.kind = 3'(k); e.fclr = 1;
    e.msr = msr;
    e.msr[14] = msr[13]; e.msr[12] = msr[11];
    e.msr[13] = 0;       e.msr[11] = 0;
    if (k == 1) begin
      e.msr[1] = 0; e.lwe = 1; e.lidx = 14; e.ldat = pc; e.pc = BASE + 32'h10;
    end else if (k == 2) begin
      e.msr[3] = 1; e.lwe = 1; e.lidx = 16; e.ldat = pc; e.pc = BASE + 32'h18;
    end else if (k == 3) begin
      e.msr[3] = 1; e.pc = btgt;
    end else begin
      e.msr[9] = 1; e.lwe = 1; e.lidx = 17; e.pc = BASE + 32'h20;
      e.ewe = 1;
      if (dslot) begin e.bwe = 1; e.btr = btgt; end
      if (k == 4) begin
        e.ldat = pc + 4;
        e.esr = esr; e.esr[12] = dslot;
      end else begin
        if (dslot) e.ldat = brimm ? pc - 8 : pc - 4;
        else if (imm) e.ldat = pc - 4;
        else e.ldat = pc;
        e.esr = 32'd16 + (miss ? 32'd2 : 32'd0) + (ifet ? 32'd1 : 32'd0);
        e.esr[10] = store; e.esr[12] = dslot;
        e.awe = 1; e.ear = maddr;
      end
    end
    return e;
  endfunction

  task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic cmp_all(string tag, exp_t act, exp_t exp);
    cmp(tag, "take",  32'(act.take), 32'(exp.take));
    cmp(tag, "kind",  32'(act.kind), 32'(exp.kind));
    cmp(tag, "pc",    act.pc,  exp.pc);
    cmp(tag, "msr",   act.msr, exp.msr);
    cmp(tag, "link",  {act.lwe, act.lidx, act.ldat[25:0]}, {exp.lwe, exp.lidx, exp.ldat[25:0]});
    cmp(tag, "ldata", act.ldat, exp.ldat);
    cmp(tag, "esr",   {31'd0, act.ewe} ^ act.esr, {31'd0, exp.ewe} ^ exp.esr);
    cmp(tag, "esrwe", 32'(act.ewe), 32'(exp.ewe));
    cmp(tag, "ear",   act.ear, exp.ear);
    cmp(tag, "earwe", 32'(act.awe), 32'(exp.awe));
    cmp(tag, "btr",   act.btr, exp.btr);
    cmp(tag, "btrwe", 32'(act.bwe), 32'(exp.bwe));
    cmp(tag, "fclr",  32'(act.fclr), 32'(exp.fclr));
  endtask

  // inputs are changed just after a falling edge; outputs are judged at the next falling edge
  task automatic step(string tag);
    exp_t ea = model(1'b1);
    exp_t eb = model(1'b0);
    @(negedge clk);
    cmp_all(tag, a, ea);
    cmp_all({tag, " [no-exc build]"}, b, eb);
  endtask

  task automatic idle();
    irq = 0; hwexc = 0; hwbrk = 0; swbrk = 0; mmu = 0;
    miss = 0; ifet = 0; store = 0; dslot = 0; imm = 0; brimm = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_all("R13 reset state", a, '0);
    rst = 0;
    pc = 32'h0000_1000; btgt = 32'h0000_2468; esr = 32'h0000_00A5; maddr = 32'hDEAD_BEE0;
    msr = 32'h0000_2802;                       // IE, VM, UM set
    idle(); step("R13 idle after reset");

    irq = 1; step("R2 R4 R1 R3 irq taken");
    msr = 32'h0000_2800; step("R2 irq masked by IE clear");
    msr = 32'h0000_2A02; step("R2 irq blocked by EIP");
    msr = 32'h0000_280A; step("R2 irq blocked by BIP");
    msr = 32'h0000_2802; dslot = 1; step("R2 irq blocked in delay slot");
    dslot = 0; imm = 1; step("R2 irq blocked after prefix");
    idle(); pc = 32'h0000_1100; irq = 1; step("R13 back-to-back irq first");
    pc = 32'h0000_1104; step("R13 back-to-back irq second");

    idle(); hwexc = 1; step("R6 R10 hw exception");
    dslot = 1; step("R6 R7 hw exception in delay slot");

    idle(); mmu = 1; step("R9 data protection fault");
    ifet = 1; step("R9 fetch protection fault");
    ifet = 0; miss = 1; store = 1; step("R9 store miss");
    ifet = 1; store = 0; step("R9 fetch miss");
    ifet = 0; dslot = 1; step("R8 R7 fault in delay slot");
    brimm = 1; step("R8 fault in delay slot after prefixed branch");
    dslot = 0; brimm = 0; imm = 1; step("R8 R11 fault after prefix only");

    idle(); msr = 32'h0000_0802; hwbrk = 1; step("R5 R1 hardware break");
    idle(); msr = 32'h0000_2000; swbrk = 1; step("R5 software break");

    idle(); msr = 32'h0000_2802; mmu = 1; hwexc = 1; irq = 1; step("R12 fault beats exception and irq");
    idle(); hwexc = 1; hwbrk = 1; step("R12 R10 exception beats hw break");
    idle(); hwbrk = 1; swbrk = 1; irq = 1; step("R12 hw break beats sw break and irq");
    idle(); swbrk = 1; irq = 1; step("R12 sw break beats irq");
    idle(); hwexc = 1; irq = 1; step("R10 suppressed exception yields to irq");
    idle(); step("R13 quiet after entries");

    report();
  end
endmodule